// File: doc/BRIEF.md
# Floating-Point Adder with Sequential Post-Normalization

This block adds or subtracts two sign-magnitude floating-point operands. Each operand has a sign bit, a two's complement exponent and an unsigned fractional mantissa. On a start pulse the block aligns the operands, combines their magnitudes and captures the result together with the carry. To align, it shifts the mantissa with the smaller exponent right by the exponent difference. To combine, it adds the magnitudes when the effective signs agree and subtracts the smaller from the larger when they differ.

A normalization loop then runs for one cycle per step. At each step it checks, in a fixed order:
- a captured carry, which gives either a right shift or an overflow;
- an already-normalized mantissa;
- a zero mantissa;
- the minimum exponent, which gives either a left shift or an underflow.

A single-cycle done pulse marks the end of the operation. The result and both error flags then hold until the next accepted start. Rounding is not performed: bits shifted out during alignment are dropped.

Top module: `fp_addsub_norm`

## Requirements
- R1: An operand is {sign, exponent, mantissa}. A sign of 1 means negative. The exponent is EW-bit two's complement (default 6). The mantissa is MW bits (default 8) read as the fraction 0.m. With `sub`=1 the sign of operand B is inverted before the operation.
- R2: The mantissa of the operand with the smaller exponent is shifted right, with truncation, by the exponent difference. The result takes the larger exponent. A difference of MW or more aligns that mantissa to zero.
- R3: Like effective signs add the aligned magnitudes. Unlike signs subtract the smaller aligned magnitude from the larger, and the result takes the sign of the larger one.
- R4: When the magnitude sum carries out and the exponent is below its maximum, the mantissa shifts right once with the carry entering the top bit, and the exponent increments.
- R5: A result whose mantissa top bit is set completes without further change. Done is asserted two clock edges after the start edge, counting the start edge.
- R6: A zero mantissa completes with exponent 0 and a positive sign.
- R7: A nonzero unnormalized mantissa shifts left one bit per cycle, and the exponent decrements by one with each shift. Each shift adds one cycle of latency.
- R8: If the exponent is at its minimum (-2^(EW-1)) and the mantissa is still unnormalized, `unf` is set. The result keeps exponent -2^(EW-1) and the unnormalized mantissa.
- R9: A carry when the exponent equals its maximum (2^(EW-1)-1) sets `ovf` and leaves the exponent at that maximum.
- R10: `done` is high for exactly one cycle per operation. The result, `ovf` and `unf` hold their values until the next accepted start.
- R11: A start pulse arriving while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| sub | input | 1 | 1 = A minus B, 0 = A plus B |
| a_sign | input | 1 | Sign of operand A |
| a_exp | input | EW | Exponent of operand A |
| a_man | input | MW | Mantissa of operand A |
| b_sign | input | 1 | Sign of operand B |
| b_exp | input | EW | Exponent of operand B |
| b_man | input | MW | Mantissa of operand B |
| r_sign | output | 1 | Result sign |
| r_exp | output | EW | Result exponent |
| r_man | output | MW | Result mantissa |
| ovf | output | 1 | Exponent overflow flag |
| unf | output | 1 | Exponent underflow flag |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest condition to reach is an underflow. The loop must still be shifting left when the exponent is already at its minimum, so a cancellation has to happen right at the bottom of the exponent range. The stimulus subtracts near-equal mantissas whose exponents are both at the minimum, and this produces that case. A second vector starts one exponent higher, so that exactly one shift lands on the minimum with a normalized mantissa. The bench checks both the underflow and the boundary just above it, and checks the latency of a three-shift cancellation cycle by cycle.

// File: rtl/fp_addsub_norm.sv
module fp_addsub_norm #(
  parameter int EW = 6,
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          sub,
  input  logic          a_sign,
  input  logic [EW-1:0] a_exp,
  input  logic [MW-1:0] a_man,
  input  logic          b_sign,
  input  logic [EW-1:0] b_exp,
  input  logic [MW-1:0] b_man,
  output logic          r_sign,
  output logic [EW-1:0] r_exp,
  output logic [MW-1:0] r_man,
  output logic          ovf,
  output logic          unf,
  output logic          done
);

  localparam logic signed [EW-1:0] EMAX_E = {1'b0, {(EW-1){1'b1}}};
  localparam logic signed [EW-1:0] EMIN_E = {1'b1, {(EW-1){1'b0}}};

  typedef enum logic {IDLE, NORM} st_t;
  st_t st;

  logic signed [EW-1:0] ea, eb, ex;
  logic signed [EW:0]   dexp;
  logic [EW:0]          dmag;
  logic                 a_big, bs, sx, sy, same, x_ge_y;
  logic [MW-1:0]        mx, my_raw, my, acc;
  logic [MW:0]          sum;
  logic                 cy, sg;

  assign ea     = $signed(a_exp);
  assign eb     = $signed(b_exp);
  assign bs     = b_sign ^ sub;
  assign a_big  = ea >= eb;
  assign dexp   = {ea[EW-1], ea} - {eb[EW-1], eb};
  assign dmag   = a_big ? dexp : -dexp;
  assign mx     = a_big ? a_man : b_man;
  assign my_raw = a_big ? b_man : a_man;
  assign sx     = a_big ? a_sign : bs;
  assign sy     = a_big ? bs : a_sign;
  assign my     = (dmag >= (EW+1)'(MW)) ? '0 : (my_raw >> dmag);
  assign same   = sx == sy;
  assign x_ge_y = mx >= my;

  always_comb begin
    if (same)        sum = {1'b0, mx} + {1'b0, my};
    else if (x_ge_y) sum = {1'b0, mx - my};
    else             sum = {1'b0, my - mx};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= IDLE;
      acc  <= '0;
      cy   <= 1'b0;
      ex   <= '0;
      sg   <= 1'b0;
      ovf  <= 1'b0;
      unf  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          acc <= sum[MW-1:0];
          cy  <= sum[MW];
          ex  <= a_big ? ea : eb;
          sg  <= (same || x_ge_y) ? sx : sy;
          ovf <= 1'b0;
          unf <= 1'b0;
          st  <= NORM;
        end
        NORM: begin
          if (cy) begin
            if (ex == EMAX_E) begin
              ovf <= 1'b1;
            end else begin
              acc <= {1'b1, acc[MW-1:1]};
              cy  <= 1'b0;
              ex  <= ex + 1'b1;
            end
            done <= 1'b1;
            st   <= IDLE;
          end else if (acc[MW-1]) begin
            done <= 1'b1;
            st   <= IDLE;
          end else if (acc == '0) begin
            ex   <= '0;
            sg   <= 1'b0;
            done <= 1'b1;
            st   <= IDLE;
          end else if (ex > EMIN_E) begin
            acc <= acc << 1;
            ex  <= ex - 1'b1;
          end else begin
            unf  <= 1'b1;
            done <= 1'b1;
            st   <= IDLE;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  assign r_sign = sg;
  assign r_exp  = ex;
  assign r_man  = acc;

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_ovf_at_max_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> done && (r_exp == EMAX_E));

  assert_normalized_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ovf && !unf && r_man != '0) |-> r_man[MW-1]);

  assert_zero_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ovf && r_man == '0) |-> (r_exp == '0) && !r_sign);

  assert_unf_at_min_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unf) |-> done && (r_exp == EMIN_E) && !r_man[MW-1]);

endmodule

// File: tb/fp_addsub_norm_tb.sv
module fp_addsub_norm_tb;
  localparam int EW = 6;
  localparam int MW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, sub = 1'b0;
  logic a_sign = 1'b0, b_sign = 1'b0;
  logic [EW-1:0] a_exp = '0, b_exp = '0;
  logic [MW-1:0] a_man = '0, b_man = '0;
  logic r_sign, ovf, unf, done;
  logic [EW-1:0] r_exp;
  logic [MW-1:0] r_man;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  fp_addsub_norm #(.EW(EW), .MW(MW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sub(sub),
    .a_sign(a_sign), .a_exp(a_exp), .a_man(a_man),
    .b_sign(b_sign), .b_exp(b_exp), .b_man(b_man),
    .r_sign(r_sign), .r_exp(r_exp), .r_man(r_man),
    .ovf(ovf), .unf(unf), .done(done)
  );

  task automatic chk(input string tag, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp_v);
    end
  endtask

  task automatic launch(input logic sa, input logic [EW-1:0] ea, input logic [MW-1:0] ma,
                        input logic s, input logic sb, input logic [EW-1:0] eb,
                        input logic [MW-1:0] mb);
    @(negedge clk);
    a_sign = sa; a_exp = ea; a_man = ma;
    b_sign = sb; b_exp = eb; b_man = mb; sub = s;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 1;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_op(input string tag,
                        input logic sa, input logic [EW-1:0] ea, input logic [MW-1:0] ma,
                        input logic s, input logic sb, input logic [EW-1:0] eb,
                        input logic [MW-1:0] mb,
                        input logic xs, input logic [EW-1:0] xe, input logic [MW-1:0] xm,
                        input logic xo, input logic xu, input int xlat);
    int lat;
    launch(sa, ea, ma, s, sb, eb, mb);
    wait_done(lat);
    chk({tag, " done seen"}, int'(done), 1);
    if (xlat > 0) chk({tag, " latency"}, lat, xlat);
    chk({tag, " ovf"}, int'(ovf), int'(xo));
    chk({tag, " unf"}, int'(unf), int'(xu));
    chk({tag, " exp"}, int'(r_exp), int'(xe));
    if (!xo) begin
      chk({tag, " man"}, int'(r_man), int'(xm));
      chk({tag, " sign"}, int'(r_sign), int'(xs));
    end
    @(negedge clk);
    chk({tag, " done one cycle R10"}, int'(done), 0);
  endtask

  task automatic t_busy_start;
    int lat;
    launch(1'b0, 6'h00, 8'h80, 1'b1, 1'b0, 6'h00, 8'h70);
    @(negedge clk);
    a_man = 8'hC0; b_man = 8'h10; sub = 1'b0; a_exp = 6'h05;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(lat);
    chk("R11 busy start ignored: exp", int'(r_exp), 'h3D);
    chk("R11 busy start ignored: man", int'(r_man), 'h80);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R11 no second done", int'(done), 0);
    end
    chk("R10 result held: exp", int'(r_exp), 'h3D);
    chk("R10 result held: man", int'(r_man), 'h80);
  endtask

  initial begin
    #20000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("reset done", int'(done), 0);
    chk("reset ovf", int'(ovf), 0);
    chk("reset unf", int'(unf), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op("R5 R1 plain add", 0, 6'h01, 8'h80, 0, 0, 6'h01, 8'h20, 0, 6'h01, 8'hA0, 0, 0, 2);
    run_op("R4 carry right shift", 0, 6'h02, 8'hC0, 0, 0, 6'h02, 8'hC0, 0, 6'h03, 8'hC0, 0, 0, 2);
    run_op("R2 align by 2", 0, 6'h03, 8'h80, 0, 0, 6'h01, 8'h80, 0, 6'h03, 8'hA0, 0, 0, 2);
    run_op("R2 align B larger exp", 0, 6'h3F, 8'h80, 0, 0, 6'h01, 8'h80, 0, 6'h01, 8'hA0, 0, 0, 2);
    run_op("R2 diff 7 truncate", 0, 6'h00, 8'h80, 0, 0, 6'h39, 8'hFF, 0, 6'h00, 8'h81, 0, 0, 2);
    run_op("R2 diff 8 to zero", 0, 6'h00, 8'h80, 0, 0, 6'h38, 8'hFF, 0, 6'h00, 8'h80, 0, 0, 2);
    run_op("R2 diff 10 to zero", 0, 6'h00, 8'h80, 0, 0, 6'h36, 8'hFF, 0, 6'h00, 8'h80, 0, 0, 2);
    run_op("R7 three left shifts", 0, 6'h00, 8'h80, 1, 0, 6'h00, 8'h70, 0, 6'h3D, 8'h80, 0, 0, 5);
    run_op("R3 sign of larger", 0, 6'h00, 8'h40, 0, 1, 6'h00, 8'hC0, 1, 6'h00, 8'h80, 0, 0, 2);
    run_op("R1 R3 sub of negative", 0, 6'h01, 8'h80, 1, 1, 6'h01, 8'h80, 0, 6'h02, 8'h80, 0, 0, 2);
    run_op("R3 neg minus pos", 1, 6'h02, 8'h90, 1, 0, 6'h02, 8'h30, 1, 6'h02, 8'hC0, 0, 0, 2);
    run_op("R6 zero by sub", 0, 6'h05, 8'h90, 1, 0, 6'h05, 8'h90, 0, 6'h00, 8'h00, 0, 0, 2);
    run_op("R6 zero positive sign", 1, 6'h05, 8'h90, 0, 0, 6'h05, 8'h90, 0, 6'h00, 8'h00, 0, 0, 2);
    run_op("R9 overflow at max", 0, 6'h1F, 8'h80, 0, 0, 6'h1F, 8'h80, 0, 6'h1F, 8'h00, 1, 0, 2);
    run_op("R4 carry just below max", 0, 6'h1E, 8'h80, 0, 0, 6'h1E, 8'h80, 0, 6'h1F, 8'h80, 0, 0, 2);
    run_op("R8 underflow at min", 0, 6'h20, 8'h80, 1, 0, 6'h20, 8'h40, 0, 6'h20, 8'h40, 0, 1, 2);
    run_op("R7 shift lands on min", 0, 6'h21, 8'h80, 1, 0, 6'h21, 8'h40, 0, 6'h20, 8'h80, 0, 0, 3);
    t_busy_start();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule